// File: doc/BRIEF.md
# Dual Page Translation Buffer with Register Commands

This block holds two small page translation buffers side by side. One serves instruction fetches and the other serves data accesses. Each maps 4 KB virtual pages onto physical page frames. Each buffer answers a lookup in the same cycle with a translated address, or it raises a one-cycle miss flag and records the virtual address that missed.

Software programs both buffers through a small group of control-status registers. Two staging registers hold a virtual page and a physical page. A command register then acts on either buffer: it can install an entry, drop one entry, flush every entry, or switch translation on or off. Translation applies only while the processor runs in user mode. In kernel mode, or while a buffer is switched off, addresses pass straight through.

Each buffer is direct-mapped. The entry count is a parameter, 64 by default. The low bits of the virtual page number select the slot, and the remaining bits form the tag.

Top module: `dual_xlat_buf`

## Requirements
- R1: After reset both buffers are disabled and hold no valid entry. Reading register index 0x1c returns 0, and a user-mode lookup passes its address through with no miss.
- R2: To install a mapping, software writes the virtual page to index 0x1d, then the physical page to index 0x1e, then the write-entry command (0x4 for the instruction buffer, 0x5 for the data buffer). A later user-mode lookup of that page on an enabled buffer returns the physical frame. Bit 0 and the other low 12 bits of the staged values are ignored.
- R3: Output address bits 11:0 always equal input address bits 11:0.
- R4: A lookup that is requested, in user mode, on an enabled buffer, and finds no valid entry with a matching tag raises that buffer's miss flag in the same cycle and outputs the input address unchanged. With the request low, the miss flag is low.
- R5: On the clock edge of a miss, the buffer captures the full virtual address. The instruction buffer's capture reads at index 0x1e and the data buffer's at index 0x1d. The capture holds until the next miss.
- R6: In kernel mode (user_mode low) the output address equals the input address and no miss is raised, whatever the enable state.
- R7: Command 0x10/0x11 enables and 0x08/0x09 disables the instruction/data buffer. A disabled buffer passes addresses through with no miss and keeps its entries.
- R8: Bit 0 of a command selects the target: 0 means the instruction buffer and 1 means the data buffer. A command never changes the other buffer.
- R9: Command 0x2/0x3 invalidates every entry of the selected buffer in one cycle.
- R10: Command 0x20/0x21 invalidates the slot indexed by the staged virtual page only when that slot holds a valid entry whose tag matches the staged page. Otherwise nothing changes.
- R11: The slot index is the low log2(ENTRIES) bits of the virtual page number (address bits 31:12). Installing a page into an occupied slot replaces the previous entry.
- R12: A command value whose bits 31:1 are not exactly 0x1, 0x2, 0x4, 0x8 or 0x10 has no effect. Writes to index 0x1f have no effect.
- R13: Reading index 0x1c returns the instruction buffer's enable in bit 0 and the data buffer's enable in bit 1, with all other bits 0. Index 0x1f and all other unused indices read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | High when the processor runs in user mode |
| csr_we | input | 1 | Register write strobe |
| csr_wr_sel | input | 5 | Register index for the write |
| csr_wr_val | input | 32 | Register write data |
| csr_rd_sel | input | 5 | Register index for the read |
| csr_rd_val | output | 32 | Register read data (combinational) |
| ifetch_req | input | 1 | Instruction lookup valid |
| ifetch_vaddr | input | 32 | Instruction virtual address |
| ifetch_paddr | output | 32 | Instruction output address |
| ifetch_miss | output | 1 | Instruction lookup missed |
| dacc_req | input | 1 | Data lookup valid |
| dacc_vaddr | input | 32 | Data virtual address |
| dacc_paddr | output | 32 | Data output address |
| dacc_miss | output | 1 | Data lookup missed |

## Verification
The assertions take for granted that user_mode, both lookup requests and their addresses, and the register strobe with its index and data carry known values on every clock edge after reset. They also assume at most one register write arrives per cycle, which the single write port enforces. The stimulus meets these conditions: every input is driven to a defined value from the first cycle, and inputs change only on falling edges. Each request is held for exactly one cycle and then dropped, so every miss pulse and every address capture falls on a known rising edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned AW        = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned VPN_W     = AW - PAGE_BITS;
  localparam int unsigned SEL_W     = 5;

  localparam logic [SEL_W-1:0] SEL_CMD    = 5'h1c;
  localparam logic [SEL_W-1:0] SEL_VSTAGE = 5'h1d;
  localparam logic [SEL_W-1:0] SEL_PSTAGE = 5'h1e;
  localparam logic [SEL_W-1:0] SEL_DBG    = 5'h1f;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH,
    OP_WRITE,
    OP_DISABLE,
    OP_ENABLE,
    OP_INVAL
  } xlat_op_e;

  // page number of an address
  function automatic logic [VPN_W-1:0] page_num(input logic [AW-1:0] a);
    return a[AW-1:PAGE_BITS];
  endfunction

  // frame joined with the in-page offset of an address
  function automatic logic [AW-1:0] join_addr(input logic [VPN_W-1:0] frame,
                                              input logic [AW-1:0] a);
    return {frame, a[PAGE_BITS-1:0]};
  endfunction

  // command word to operation; bit 0 is the side selector, not part of the code
  function automatic xlat_op_e decode_op(input logic [AW-1:0] d);
    case (d[AW-1:1])
      31'h01:  return OP_FLUSH;
      31'h02:  return OP_WRITE;
      31'h04:  return OP_DISABLE;
      31'h08:  return OP_ENABLE;
      31'h10:  return OP_INVAL;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/xlat_csr_front.sv
module xlat_csr_front
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [AW-1:0]    wdata,
  output logic [AW-1:0]    stage_v,
  output logic [AW-1:0]    stage_p,
  output xlat_op_e         op_ifetch,
  output xlat_op_e         op_dacc
);

  logic     cmd_wr;
  xlat_op_e cmd_op;

  assign cmd_wr = we && (sel == SEL_CMD);
  assign cmd_op = cmd_wr ? decode_op(wdata) : OP_NONE;

  // bit 0 routes the command to one side only
  assign op_ifetch = wdata[0] ? OP_NONE : cmd_op;
  assign op_dacc   = wdata[0] ? cmd_op  : OP_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_v <= '0;
      stage_p <= '0;
    end else if (we) begin
      if (sel == SEL_VSTAGE) stage_v <= wdata;
      if (sel == SEL_PSTAGE) stage_p <= wdata;
    end
  end

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xlat_op_e      op,
  input  logic [AW-1:0] stage_v,
  input  logic [AW-1:0] stage_p,
  input  logic          user_mode,
  input  logic          req,
  input  logic [AW-1:0] vaddr,
  output logic [AW-1:0] paddr,
  output logic          miss,
  output logic          enabled,
  output logic [AW-1:0] fault_addr,
  output logic          any_valid
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  function automatic logic [IDX_W-1:0] slot_of(input logic [VPN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:IDX_W];
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [VPN_W-1:0]   frame_q [ENTRIES];
  logic               en_q;
  logic [AW-1:0]      fault_q;

  // lookup path
  logic [VPN_W-1:0] l_vpn;
  logic [IDX_W-1:0] l_idx;
  logic             l_hit;
  logic             xlat_on;

  assign l_vpn   = page_num(vaddr);
  assign l_idx   = slot_of(l_vpn);
  assign l_hit   = valid_q[l_idx] && (tag_q[l_idx] == tag_of(l_vpn));
  assign xlat_on = en_q && user_mode;
  assign miss    = req && xlat_on && !l_hit;
  assign paddr   = (xlat_on && l_hit) ? join_addr(frame_q[l_idx], vaddr) : vaddr;

  // staged page for commands
  logic [VPN_W-1:0] s_vpn;
  logic [IDX_W-1:0] s_idx;
  logic             s_match;

  assign s_vpn   = page_num(stage_v);
  assign s_idx   = slot_of(s_vpn);
  assign s_match = valid_q[s_idx] && (tag_q[s_idx] == tag_of(s_vpn));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      en_q    <= 1'b0;
      fault_q <= '0;
    end else begin
      case (op)
        OP_FLUSH:   valid_q <= '0;
        OP_WRITE:   valid_q[s_idx] <= 1'b1;
        OP_INVAL:   if (s_match) valid_q[s_idx] <= 1'b0;
        OP_ENABLE:  en_q <= 1'b1;
        OP_DISABLE: en_q <= 1'b0;
        default:    ;
      endcase
      if (miss) fault_q <= vaddr;
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_WRITE) begin
      tag_q[s_idx]   <= tag_of(s_vpn);
      frame_q[s_idx] <= page_num(stage_p);
    end
  end

  assign enabled    = en_q;
  assign fault_addr = fault_q;
  assign any_valid  = |valid_q;

endmodule

// File: rtl/dual_xlat_buf.sv
module dual_xlat_buf
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             user_mode,
  input  logic             csr_we,
  input  logic [SEL_W-1:0] csr_wr_sel,
  input  logic [AW-1:0]    csr_wr_val,
  input  logic [SEL_W-1:0] csr_rd_sel,
  output logic [AW-1:0]    csr_rd_val,
  input  logic             ifetch_req,
  input  logic [AW-1:0]    ifetch_vaddr,
  output logic [AW-1:0]    ifetch_paddr,
  output logic             ifetch_miss,
  input  logic             dacc_req,
  input  logic [AW-1:0]    dacc_vaddr,
  output logic [AW-1:0]    dacc_paddr,
  output logic             dacc_miss
);

  localparam int unsigned SIDES = 2;

  logic [AW-1:0]   stage_v, stage_p;
  xlat_op_e        side_op [SIDES];

  logic [SIDES-1:0]         side_req, side_miss, side_en, side_any;
  logic [SIDES-1:0][AW-1:0] side_va, side_pa, side_fault;

  // named events for the checker
  logic [SIDES-1:0] flush_ev, enable_ev, disable_ev, cmd_hit;

  xlat_csr_front u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (csr_we),
    .sel       (csr_wr_sel),
    .wdata     (csr_wr_val),
    .stage_v   (stage_v),
    .stage_p   (stage_p),
    .op_ifetch (side_op[0]),
    .op_dacc   (side_op[1])
  );

  assign side_req = {dacc_req, ifetch_req};
  assign side_va  = {dacc_vaddr, ifetch_vaddr};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    xlat_buf #(.ENTRIES(ENTRIES)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (side_op[s]),
      .stage_v    (stage_v),
      .stage_p    (stage_p),
      .user_mode  (user_mode),
      .req        (side_req[s]),
      .vaddr      (side_va[s]),
      .paddr      (side_pa[s]),
      .miss       (side_miss[s]),
      .enabled    (side_en[s]),
      .fault_addr (side_fault[s]),
      .any_valid  (side_any[s])
    );
    assign flush_ev[s]   = (side_op[s] == OP_FLUSH);
    assign enable_ev[s]  = (side_op[s] == OP_ENABLE);
    assign disable_ev[s] = (side_op[s] == OP_DISABLE);
    assign cmd_hit[s]    = (side_op[s] != OP_NONE);
  end

  assign ifetch_paddr = side_pa[0];
  assign ifetch_miss  = side_miss[0];
  assign dacc_paddr   = side_pa[1];
  assign dacc_miss    = side_miss[1];

  always_comb begin
    case (csr_rd_sel)
      SEL_CMD:    csr_rd_val = {{(AW-2){1'b0}}, side_en[1], side_en[0]};
      SEL_VSTAGE: csr_rd_val = side_fault[1];
      SEL_PSTAGE: csr_rd_val = side_fault[0];
      default:    csr_rd_val = '0;
    endcase
  end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk
  import xlat_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                user_mode,
  input logic [1:0]          req,
  input logic [1:0]          miss,
  input logic [1:0]          en,
  input logic [1:0]          any_valid,
  input logic [1:0]          flush_ev,
  input logic [1:0]          enable_ev,
  input logic [1:0]          disable_ev,
  input logic [1:0]          cmd_hit,
  input logic [1:0][AW-1:0]  va,
  input logic [1:0][AW-1:0]  pa,
  input logic [1:0][AW-1:0]  fault
);

  p_one_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_hit));

  for (genvar s = 0; s < 2; s++) begin : g_chk
    p_kernel_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !user_mode |-> (pa[s] == va[s]) && !miss[s]);

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pa[s][PAGE_BITS-1:0] == va[s][PAGE_BITS-1:0]);

    p_miss_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
      miss[s] |-> req[s] && user_mode && en[s]);

    p_miss_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
      miss[s] |-> pa[s] == va[s]);

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en[s] |-> !miss[s] && (pa[s] == va[s]));

    p_fault_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      miss[s] |=> fault[s] == $past(va[s]));

    p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !miss[s] |=> $stable(fault[s]));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_ev[s] |=> !any_valid[s]);

    p_enable_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      enable_ev[s] |=> en[s]);

    p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      disable_ev[s] |=> !en[s]);
  end

endmodule

bind dual_xlat_buf xlat_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .user_mode  (user_mode),
  .req        (side_req),
  .miss       (side_miss),
  .en         (side_en),
  .any_valid  (side_any),
  .flush_ev   (flush_ev),
  .enable_ev  (enable_ev),
  .disable_ev (disable_ev),
  .cmd_hit    (cmd_hit),
  .va         (side_va),
  .pa         (side_pa),
  .fault      (side_fault)
);

// File: tb/dual_xlat_buf_tb_top.sv
module dual_xlat_buf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        user_mode = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_wr_sel = '0;
  logic [31:0] csr_wr_val = '0;
  logic [4:0]  csr_rd_sel = '0;
  logic [31:0] csr_rd_val;
  logic        ifetch_req = 1'b0;
  logic [31:0] ifetch_vaddr = '0;
  logic [31:0] ifetch_paddr;
  logic        ifetch_miss;
  logic        dacc_req = 1'b0;
  logic [31:0] dacc_vaddr = '0;
  logic [31:0] dacc_paddr;
  logic        dacc_miss;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_xlat_buf #(.ENTRIES(N_ENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .csr_we(csr_we), .csr_wr_sel(csr_wr_sel), .csr_wr_val(csr_wr_val),
    .csr_rd_sel(csr_rd_sel), .csr_rd_val(csr_rd_val),
    .ifetch_req(ifetch_req), .ifetch_vaddr(ifetch_vaddr),
    .ifetch_paddr(ifetch_paddr), .ifetch_miss(ifetch_miss),
    .dacc_req(dacc_req), .dacc_vaddr(dacc_vaddr),
    .dacc_paddr(dacc_paddr), .dacc_miss(dacc_miss)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [4:0] sel, input logic [31:0] val);
    @(negedge clk);
    csr_we = 1'b1; csr_wr_sel = sel; csr_wr_val = val;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [4:0] sel, output logic [31:0] val);
    csr_rd_sel = sel;
    #1;
    val = csr_rd_val;
  endtask

  // one-cycle lookup; outputs sampled mid-cycle, request dropped at next falling edge
  task automatic look(input bit side, input logic [31:0] va, input bit usr,
                      output logic [31:0] pa, output logic m);
    @(negedge clk);
    user_mode = usr;
    if (side) begin dacc_req = 1'b1; dacc_vaddr = va; end
    else      begin ifetch_req = 1'b1; ifetch_vaddr = va; end
    #1;
    pa = side ? dacc_paddr : ifetch_paddr;
    m  = side ? dacc_miss  : ifetch_miss;
    @(negedge clk);
    ifetch_req = 1'b0; dacc_req = 1'b0;
  endtask

  // staged values carry junk low bits and the side flag, which must be ignored
  task automatic map(input bit side, input logic [19:0] vpn, input logic [19:0] pfn);
    csr_wr(5'h1d, {vpn, 12'h7a0} | 32'(side));
    csr_wr(5'h1e, {pfn, 12'h354} | 32'(side));
    csr_wr(5'h1c, 32'h4 | 32'(side));
  endtask

  function automatic logic [31:0] xl(input logic [19:0] pfn, input logic [31:0] va);
    return (32'(pfn) << 12) | (va & 32'hfff);
  endfunction

  function automatic logic [19:0] frame_for(input bit side, input int k);
    return 20'h800 + 20'(16 * side) + 20'(k);
  endfunction

  // expect a hit on frame pfn
  task automatic expect_hit(input string tag, input bit side, input logic [31:0] va,
                            input logic [19:0] pfn);
    logic [31:0] pa; logic m;
    look(side, va, 1'b1, pa, m);
    chk({tag, " miss"}, 32'(m), 32'd0);
    chk({tag, " paddr"}, pa, xl(pfn, va));
  endtask

  task automatic expect_miss(input string tag, input bit side, input logic [31:0] va);
    logic [31:0] pa; logic m;
    look(side, va, 1'b1, pa, m);
    chk({tag, " miss"}, 32'(m), 32'd1);
    chk({tag, " paddr"}, pa, va);
  endtask

  initial begin
    logic [31:0] rd, pa;
    logic m;
    logic [31:0] offs [4];
    offs[0] = 32'h000; offs[1] = 32'h004; offs[2] = 32'hffc; offs[3] = 32'h7a8;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    csr_rd(5'h1c, rd); chk("R1 enables after reset", rd, 32'h0);
    look(1'b0, 32'h0012_3456, 1'b1, pa, m);
    chk("R1 no miss when disabled", 32'(m), 32'd0);
    chk("R1 passthrough when disabled", pa, 32'h0012_3456);
    csr_rd(5'h1f, rd); chk("R13 debug index reads zero", rd, 32'h0);

    // R7 / R13 enable both
    csr_wr(5'h1c, 32'h10);
    csr_rd(5'h1c, rd); chk("R13 ifetch enable bit0", rd, 32'h1);
    csr_wr(5'h1c, 32'h11);
    csr_rd(5'h1c, rd); chk("R7 both enabled", rd, 32'h3);

    // R1 no valid entries after reset
    expect_miss("R1 empty buffer", 1'b0, 32'h0010_1000);

    // R2 / R3 / R11 install one page per slot on both sides, sweep offsets
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < N_ENT; k++)
        map(s[0], 20'h100 + 20'(k), frame_for(s[0], k));
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < N_ENT; k++)
        for (int o = 0; o < 4; o++)
          expect_hit("R2 R3 sweep", s[0], {20'h100 + 20'(k), 12'h000} | offs[o],
                     frame_for(s[0], k));

    // R11 same slot different tag, R4 miss, R5 capture
    expect_miss("R11 R4 tag conflict ifetch", 1'b0, 32'h0010_4010);
    #1 chk("R4 miss drops with request", 32'(ifetch_miss), 32'd0);
    csr_rd(5'h1e, rd); chk("R5 ifetch fault address", rd, 32'h0010_4010);
    expect_miss("R4 tag conflict dacc", 1'b1, 32'h0010_d020);
    csr_rd(5'h1d, rd); chk("R5 dacc fault address", rd, 32'h0010_d020);
    csr_rd(5'h1e, rd); chk("R5 ifetch fault held", rd, 32'h0010_4010);

    // R6 kernel mode
    look(1'b0, 32'h0010_4000, 1'b0, pa, m);
    chk("R6 kernel unmapped no miss", 32'(m), 32'd0);
    chk("R6 kernel unmapped passthrough", pa, 32'h0010_4000);
    look(1'b1, 32'h0010_1005, 1'b0, pa, m);
    chk("R6 kernel mapped passthrough", pa, 32'h0010_1005);

    // R12 undefined codes and debug writes
    csr_wr(5'h1c, 32'h6);
    csr_wr(5'h1c, 32'h40);
    csr_wr(5'h1c, 32'h0);
    csr_wr(5'h1c, 32'h31);
    csr_wr(5'h1c, 32'h8000_0008);
    csr_wr(5'h1f, 32'h2);
    csr_rd(5'h1c, rd); chk("R12 enables unchanged", rd, 32'h3);
    expect_hit("R12 entry survives", 1'b0, 32'h0010_1008, frame_for(1'b0, 1));
    expect_hit("R12 dacc entry survives", 1'b1, 32'h0010_3008, frame_for(1'b1, 3));

    // R10 single invalidate
    csr_wr(5'h1d, 32'h0010_5000);
    csr_wr(5'h1c, 32'h20);
    expect_hit("R10 wrong tag keeps entry", 1'b0, 32'h0010_1000, frame_for(1'b0, 1));
    csr_wr(5'h1d, 32'h0010_1000);
    csr_wr(5'h1c, 32'h20);
    expect_miss("R10 matching entry dropped", 1'b0, 32'h0010_1000);
    expect_hit("R10 other slot kept", 1'b0, 32'h0010_2000, frame_for(1'b0, 2));
    expect_hit("R8 dacc untouched by ifetch invalidate", 1'b1, 32'h0010_1000,
               frame_for(1'b1, 1));

    // R11 replacement of an occupied slot
    map(1'b0, 20'h106, 20'h901);
    expect_hit("R11 new entry", 1'b0, 32'h0010_6abc, 20'h901);
    expect_miss("R11 old entry replaced", 1'b0, 32'h0010_2abc);

    // R9 flush ifetch only
    csr_wr(5'h1c, 32'h2);
    expect_miss("R9 flushed slot0", 1'b0, 32'h0010_0000);
    expect_miss("R9 flushed slot3", 1'b0, 32'h0010_3000);
    expect_hit("R8 dacc survives ifetch flush", 1'b1, 32'h0010_0004, frame_for(1'b1, 0));

    // R7 disable / re-enable data side, entries kept
    csr_wr(5'h1c, 32'h9);
    csr_rd(5'h1c, rd); chk("R7 dacc disabled", rd, 32'h1);
    look(1'b1, 32'h0020_0004, 1'b1, pa, m);
    chk("R7 disabled no miss", 32'(m), 32'd0);
    chk("R7 disabled passthrough", pa, 32'h0020_0004);
    csr_wr(5'h1c, 32'h11);
    expect_hit("R7 entries kept across disable", 1'b1, 32'h0010_2004, frame_for(1'b1, 2));

    // R9 flush data side too
    csr_wr(5'h1c, 32'h3);
    expect_miss("R9 dacc flushed", 1'b1, 32'h0010_2004);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule